// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This unit works next to the program counter of a simple instruction sequencer and runs counted loops without spending any cycles on loop bookkeeping. A loop-setup command, fetched at some address, brings an immediate trip count and the address of the loop's last body instruction. The body starts at the address that follows the setup command. From then on the unit compares every valid fetch address with the stored end address. At the last body instruction it either sends the sequencer back to the body start or lets it continue past the end. The redirect is produced in the same cycle as the fetch of the last instruction, so the next pass begins in the very next fetch slot.

The sequencer gives the unit its fetch address and a valid flag. When the unit raises its override output, the sequencer takes the supplied next address instead of its own increment. A stalled fetch (valid low) does not use up an iteration. A trip count of zero skips the body. While a loop is active, a second setup command is ignored, because loops do not nest here. The remaining trip count and the active flag are visible on outputs.

Top module: `hwloop_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `loop_active` is 0, `loop_remaining` is 0 and `pc_override` is 0.
- R2: A setup command (`do_start` with `fetch_valid` high, no loop active) with a nonzero count produces no override in its own cycle. From the next cycle onward, `loop_active` is 1 and `loop_remaining` equals the count. The body start is the setup address plus one.
- R3: A setup command with count 0 raises `pc_override` in its own cycle with `pc_next` = end address + 1, and `loop_active` stays 0.
- R4: A valid fetch of the end address with a remaining count above 1 raises `pc_override` in that same cycle with `pc_next` = body start. On the next edge the remaining count drops by one.
- R5: A valid fetch of the end address with a remaining count of 1 raises `pc_override` with `pc_next` = end address + 1. On the next edge `loop_active` and `loop_remaining` go to 0.
- R6: In a cycle with `fetch_valid` low, `pc_override` is 0 and the loop state does not change.
- R7: While a loop is active, a valid fetch of any address other than the end address gives no override and leaves the count unchanged.
- R8: When the end address equals the start address, that single instruction is fetched once per valid cycle, for exactly the trip count.
- R9: A setup command that arrives while a loop is active is ignored: the count, the end address and the start address all keep their values.
- R10: The stream of valid fetches after a setup command with count N and body length L is the body addresses in order, repeated N times. That makes N·L fetches, with no gap between passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| do_start | input | 1 | Loop-setup command present at the current fetch |
| do_count | input | CNT_W | Trip count carried by the setup command |
| do_end | input | ADDR_W | Address of the last body instruction |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| fetch_valid | input | 1 | Fetch slot is valid (low means stalled) |
| pc_override | output | 1 | Sequencer must take `pc_next` as its next address |
| pc_next | output | ADDR_W | Redirect address, meaningful when `pc_override` is high |
| loop_active | output | 1 | A loop is in progress |
| loop_remaining | output | CNT_W | Passes still to run, including the current one |

## Verification
`pc_override` and `pc_next` come straight from logic, with no register, so they are due in the same cycle as the fetch that causes them. `loop_active` and `loop_remaining` change on the clock edge that ends that fetch cycle. The bench drives every input on the falling edge and samples one nanosecond later, before the rising edge. At that point the redirect of the current fetch is already valid, and the loop state still holds the value from before that fetch. The bench's own sequencer model follows the same timing. It compares every valid fetch address against the unrolled body order and updates its expected count only after the edge.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  // Source of the next fetch address
  typedef enum logic [1:0] {
    NPC_SEQ   = 2'd0,  // no override, sequencer increments
    NPC_START = 2'd1,  // jump back to body start
    NPC_EXIT  = 2'd2,  // leave loop after last pass
    NPC_SKIP  = 2'd3   // zero-count setup, skip body
  } npc_sel_e;
endpackage

// File: rtl/hwloop_match.sv
module hwloop_match #(
  parameter int ADDR_W = 16
) (
  input  logic              active,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [ADDR_W-1:0] end_addr,
  output logic              at_end
);
  // End-of-body detection, evaluated alongside the fetch
  always_comb begin
    at_end = active & fetch_valid & (fetch_pc == end_addr);
  end
endmodule

// File: rtl/hwloop_counter.sv
module hwloop_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             is_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec | clr;
    cnt_d  = cnt_q;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (dec)  cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign is_last = (cnt_q == ONE);
endmodule

// File: rtl/hwloop_nextpc.sv
module hwloop_nextpc
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  npc_sel_e          sel,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [ADDR_W-1:0] do_end,
  output logic              override,
  output logic [ADDR_W-1:0] pc_next
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(1);

  always_comb begin
    override = (sel != NPC_SEQ);
    unique case (sel)
      NPC_START: pc_next = start_addr;
      NPC_EXIT:  pc_next = end_addr + INC;
      NPC_SKIP:  pc_next = do_end + INC;
      default:   pc_next = fetch_pc + INC;
    endcase
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_start,
  input  logic [CNT_W-1:0]  do_count,
  input  logic [ADDR_W-1:0] do_end,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              fetch_valid,
  output logic              pc_override,
  output logic [ADDR_W-1:0] pc_next,
  output logic              loop_active,
  output logic [CNT_W-1:0]  loop_remaining
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(1);

  logic              active_q, active_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic [ADDR_W-1:0] end_q, end_d;
  logic              state_en;

  logic              accept_do;
  logic              at_end;
  logic              cnt_load, cnt_dec, cnt_clr;
  logic              cnt_last;
  logic [CNT_W-1:0]  cnt_val;
  npc_sel_e          sel;

  hwloop_match #(.ADDR_W(ADDR_W)) u_match (
    .active      (active_q),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .end_addr    (end_q),
    .at_end      (at_end)
  );

  hwloop_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (do_count),
    .dec      (cnt_dec),
    .clr      (cnt_clr),
    .cnt      (cnt_val),
    .is_last  (cnt_last)
  );

  // Next-state logic
  always_comb begin
    accept_do = do_start & fetch_valid & ~active_q;
    active_d  = active_q;
    start_d   = start_q;
    end_d     = end_q;
    state_en  = 1'b0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    cnt_clr   = 1'b0;
    sel       = NPC_SEQ;
    if (accept_do) begin
      if (do_count == '0) begin
        sel = NPC_SKIP;
      end else begin
        active_d = 1'b1;
        start_d  = fetch_pc + INC;
        end_d    = do_end;
        state_en = 1'b1;
        cnt_load = 1'b1;
      end
    end else if (at_end) begin
      if (cnt_last) begin
        sel      = NPC_EXIT;
        active_d = 1'b0;
        state_en = 1'b1;
        cnt_clr  = 1'b1;
      end else begin
        sel     = NPC_START;
        cnt_dec = 1'b1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      start_q  <= '0;
      end_q    <= '0;
    end else if (state_en) begin
      active_q <= active_d;
      start_q  <= start_d;
      end_q    <= end_d;
    end
  end

  hwloop_nextpc #(.ADDR_W(ADDR_W)) u_npc (
    .sel        (sel),
    .fetch_pc   (fetch_pc),
    .start_addr (start_q),
    .end_addr   (end_q),
    .do_end     (do_end),
    .override   (pc_override),
    .pc_next    (pc_next)
  );

  assign loop_active    = active_q;
  assign loop_remaining = cnt_val;
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              do_start,
  input logic [CNT_W-1:0]  do_count,
  input logic [ADDR_W-1:0] do_end,
  input logic              fetch_valid,
  input logic              pc_override,
  input logic [ADDR_W-1:0] pc_next,
  input logic              loop_active,
  input logic [CNT_W-1:0]  loop_remaining
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> !pc_override);

  assert_active_has_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> loop_remaining != '0);

  assert_zero_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && do_start && !loop_active && do_count == '0)
      |-> (pc_override && pc_next == do_end + ADDR_W'(1)));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && pc_override && loop_remaining > CNT_W'(1))
      |=> (loop_active && loop_remaining == $past(loop_remaining) - CNT_W'(1)));

  assert_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && pc_override && loop_remaining == CNT_W'(1))
      |=> (!loop_active && loop_remaining == '0));

  assert_override_needs_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_override |-> fetch_valid);

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> ($stable(loop_remaining) && $stable(loop_active)));

  assert_busy_setup_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && do_start && !pc_override) |=> $stable(loop_remaining));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .do_start       (do_start),
  .do_count       (do_count),
  .do_end         (do_end),
  .fetch_valid    (fetch_valid),
  .pc_override    (pc_override),
  .pc_next        (pc_next),
  .loop_active    (loop_active),
  .loop_remaining (loop_remaining)
);

// File: tb/test_hwloop_ctrl.sv
module test_hwloop_ctrl;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          do_start;
  logic [CW-1:0] do_count;
  logic [AW-1:0] do_end;
  logic [AW-1:0] fetch_pc;
  logic          fetch_valid;
  logic          pc_override;
  logic [AW-1:0] pc_next;
  logic          loop_active;
  logic [CW-1:0] loop_remaining;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hwloop_ctrl #(.ADDR_W(AW), .CNT_W(CW)) i_hwloop_ctrl (
    .clk(clk), .rst_n(rst_n), .do_start(do_start), .do_count(do_count),
    .do_end(do_end), .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
    .pc_override(pc_override), .pc_next(pc_next),
    .loop_active(loop_active), .loop_remaining(loop_remaining)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] body_addr(int base, int len, int k);
    return AW'(base + 1 + (k % len));
  endfunction

  // One loop: setup at address a, body a+1..a+l, trip count n
  task automatic run_loop(input int a, input int l, input int n,
                          input int stall_pct, input bit poke);
    logic [AW-1:0] pc;
    logic [AW-1:0] endp;
    int left, fetched, guard;
    bit poked;
    endp = AW'(a + l);
    @(negedge clk);
    fetch_pc = AW'(a); fetch_valid = 1'b1; do_start = 1'b1;
    do_count = CW'(n); do_end = endp;
    #1;
    if (n == 0) begin
      chk(pc_override == 1'b1, "R3", "skip override", pc_override, 1);
      chk(pc_next == endp + 1'b1, "R3", "skip target", pc_next, endp + 1);
      pc = pc_next;
    end else begin
      chk(pc_override == 1'b0, "R2", "no override at setup", pc_override, 0);
      pc = AW'(a + 1);
    end
    @(posedge clk);
    left = n; fetched = 0; guard = 0; poked = 1'b0;
    while (left > 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
      fetch_pc    = pc;
      fetch_valid = ($urandom_range(99) >= stall_pct);
      do_start    = poke && ($urandom_range(7) == 0);
      do_count    = CW'($urandom);
      do_end      = AW'($urandom);
      #1;
      chk(loop_active == 1'b1, guard == 1 ? "R2" : "R7", "active", loop_active, 1);
      chk(loop_remaining == CW'(left), poked ? "R9" : (guard == 1 ? "R2" : "R4"),
          "remaining", loop_remaining, left);
      poked = do_start;
      if (!fetch_valid) begin
        chk(pc_override == 1'b0, "R6", "override on stall", pc_override, 0);
      end else begin
        chk(pc == body_addr(a, l, fetched), l == 1 ? "R8" : "R10", "fetch order",
            pc, body_addr(a, l, fetched));
        fetched++;
        if (pc == endp) begin
          if (left > 1) begin
            chk(pc_override && pc_next == AW'(a + 1), l == 1 ? "R8" : "R4",
                "jump to start", pc_next, a + 1);
            left--;
            pc = AW'(a + 1);
          end else begin
            chk(pc_override && pc_next == endp + 1'b1, "R5", "exit target",
                pc_next, endp + 1);
            left = 0;
            pc = endp + 1'b1;
          end
        end else begin
          chk(pc_override == 1'b0, "R7", "no override mid-body", pc_override, 0);
          pc = pc + 1'b1;
        end
      end
      @(posedge clk);
    end
    @(negedge clk);
    do_start = 1'b0; fetch_valid = 1'b0;
    #1;
    chk(loop_active == 1'b0, "R5", "inactive after exit", loop_active, 0);
    chk(loop_remaining == '0, "R5", "count cleared", loop_remaining, 0);
    chk(fetched == n * l, l == 1 ? "R8" : "R10", "fetch total", fetched, n * l);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; do_start = 1'b0; do_count = '0; do_end = '0;
    fetch_pc = '0; fetch_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(loop_active == 1'b0, "R1", "active in reset", loop_active, 0);
    chk(loop_remaining == '0, "R1", "count in reset", loop_remaining, 0);
    chk(pc_override == 1'b0, "R1", "override in reset", pc_override, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(loop_active == 1'b0 && loop_remaining == '0, "R1", "idle after release",
        loop_active, 0);
    // Directed corners
    run_loop(16, 3, 100, 0, 1'b0);
    run_loop(40, 4, 0, 0, 1'b0);
    run_loop(60, 2, 1, 0, 1'b0);
    run_loop(80, 1, 5, 0, 1'b0);
    run_loop(90, 1, 4, 40, 1'b1);
    run_loop(100, 5, 3, 50, 1'b1);
    // Random loops
    for (int i = 0; i < 30; i++) begin
      run_loop(200 + 20 * i, $urandom_range(1, 6), $urandom_range(0, 12),
               $urandom_range(0, 60), 1'b1);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule